// File: doc/BRIEF.md
# Dual-Channel Tape Byte Codec

This block turns bytes into a two-channel pulse stream for a digital cassette head, and turns such a stream back into bytes. Each symbol is one pulse. A pulse on channel 0 alone is a zero. A pulse on channel 1 alone is a one. Pulses on both channels together are a mark, and marks delimit bytes. A byte travels as a nine-bit frame: eight data bits plus a control flag. The control flag sits in the centre of the frame, so the beginning-of-file code reads the same in either tape direction. All timing is counted in system clock ticks.

The write side accepts bytes on a valid/ready stream. It holds ready low from the moment it accepts a byte until the closing mark of that byte has been sent. A sender may keep `wr_valid` high and wait. The read side watches both head channels and groups near-simultaneous edges into marks. It keeps only frames with exactly nine bits between two marks. It delivers them on a valid/ready stream in one of two modes, data or control. The tape cannot be stopped, so back-pressure is handled as follows. An undelivered frame stays on `rd_data`, unchanged, until `rd_ready` takes it. Any frame completed in the meantime is dropped.

Top module: `tape_byte_codec`

## Requirements
- R1: The writer marks a zero with a pulse on `tape_out0` only, a one with a pulse on `tape_out1` only, and a mark with pulses on both at once. The reader decodes `tape_in0`/`tape_in1` with the same encoding.
- R2: The frame order on tape is data bits 7,6,5,4, then the control flag, then data bits 3,2,1,0. Bit 7 goes first.
- R3: Each written symbol is GAP_TICKS cycles with both outputs low, then PULSE_TICKS cycles with the selected output(s) high. Symbols within a byte therefore start GAP_TICKS+PULSE_TICKS cycles apart.
- R4: The first byte after reset is preceded by a leading mark. Every byte is followed by a closing mark. A byte after the first has no leading mark of its own, so 11 symbols are written for the first byte and 10 for each later one.
- R5: `wr_ready` is high only while the writer is idle, and both tape outputs are low whenever it is high. A byte is taken on a cycle with `wr_valid` and `wr_ready` both high. Ready returns only after the closing mark pulse has ended.
- R6: The reader opens a window on any rising input edge. Rising edges on either channel up to WIN_TICKS cycles after the first one count as part of the same symbol. Both channels seen means a mark. Edges that are further apart give two separate bits.
- R7: A frame is accepted only when exactly nine bits lie between two marks. Shorter or longer runs are discarded. Bits that arrive before the first mark after reset are ignored.
- R8: With `rd_ctrl_mode` low (data mode), every accepted frame is delivered as its eight data bits on `rd_data`. The control flag is dropped, and `rd_irq` stays low.
- R9: With `rd_ctrl_mode` high (control mode), only frames with the control flag set are delivered. Each delivery raises `rd_irq` for one cycle together with `rd_valid`. Frames with the flag clear produce nothing.
- R10: In control mode, a delivered control frame whose data is 0x3C also raises `rd_bof` for that same cycle.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. A frame completed during that time is lost.
- R12: After reset, `wr_ready` is high and `tape_out0`, `tape_out1`, `rd_valid`, `rd_irq` and `rd_bof` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is in its ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte to write is present |
| wr_ready | output | 1 | Writer idle and able to take a byte |
| wr_data | input | 8 | Data byte to write |
| wr_ctrl | input | 1 | Control flag for the byte to write |
| tape_out0 | output | 1 | Write pulse, channel 0 |
| tape_out1 | output | 1 | Write pulse, channel 1 |
| tape_in0 | input | 1 | Read pulse from channel 0 |
| tape_in1 | input | 1 | Read pulse from channel 1 |
| rd_ctrl_mode | input | 1 | 1 = control mode, 0 = data mode |
| rd_valid | output | 1 | Received byte present |
| rd_ready | input | 1 | Consumer takes the received byte |
| rd_data | output | 8 | Received data byte |
| rd_irq | output | 1 | One-cycle pulse per control frame delivered in control mode |
| rd_bof | output | 1 | One-cycle pulse when the delivered control frame is 0x3C |

## Verification
The bench builds the block with GAP_TICKS=6, PULSE_TICKS=4 and WIN_TICKS=3. With these values each symbol lasts ten cycles, so whole multi-byte files and the symbol spacing can be observed in a few hundred cycles. They also let injected edges with a skew of 2 or 3 cycles land inside the mark window, while a skew of 6 falls outside it and splits into two bits. The writer is looped back into the reader for end-to-end runs in both modes and under back-pressure. Direct injection covers short, long, unsynchronised and skewed frames.

// File: rtl/tape_codec_pkg.sv
package tape_codec_pkg;

  localparam int FRAME_BITS = 9;
  localparam int CTRL_POS   = 4;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = $clog2(FRAME_BITS + 2);

  typedef enum logic [1:0] {
    SYM_NONE = 2'b00,
    SYM_ZERO = 2'b01,
    SYM_ONE  = 2'b10,
    SYM_MARK = 2'b11
  } sym_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                        input logic c);
    return {d[7:4], c, d[3:0]};
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_BITS-1:0] f);
    return {f[8:5], f[3:0]};
  endfunction

endpackage

// File: rtl/tape_wr_serializer.sv
module tape_wr_serializer
  import tape_codec_pkg::*;
#(
  parameter int GAP_TICKS   = 6400,
  parameter int PULSE_TICKS = 4160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctrl,
  output logic              in_ready,
  output logic              ch0,
  output logic              ch1
);
  localparam int MAXT    = (GAP_TICKS > PULSE_TICKS) ? GAP_TICKS : PULSE_TICKS;
  localparam int TW      = $clog2(MAXT + 1);
  localparam int LAST_IX = FRAME_BITS + 1;

  typedef enum logic [1:0] {W_IDLE, W_GAP, W_PULSE} wst_t;

  wst_t                  st;
  logic [TW-1:0]         tcnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic                  lead_pend;
  sym_t                  cur_sym;

  // index 0 is the leading mark, 1..9 the frame bits, 10 the closing mark
  always_comb begin
    if (idx == '0 || idx == IDX_W'(LAST_IX)) cur_sym = SYM_MARK;
    else if (shreg[FRAME_BITS-1])             cur_sym = SYM_ONE;
    else                                      cur_sym = SYM_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      tcnt      <= '0;
      shreg     <= '0;
      idx       <= '0;
      lead_pend <= 1'b1;
    end else begin
      case (st)
        W_IDLE: if (in_valid) begin
          shreg     <= build_frame(in_data, in_ctrl);
          idx       <= lead_pend ? '0 : IDX_W'(1);
          lead_pend <= 1'b0;
          tcnt      <= '0;
          st        <= W_GAP;
        end
        W_GAP: begin
          if (tcnt == TW'(GAP_TICKS - 1)) begin
            tcnt <= '0;
            st   <= W_PULSE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        W_PULSE: begin
          if (tcnt == TW'(PULSE_TICKS - 1)) begin
            tcnt <= '0;
            if (idx == IDX_W'(LAST_IX)) begin
              st <= W_IDLE;
            end else begin
              if (idx != '0) shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
              idx <= idx + 1'b1;
              st  <= W_GAP;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign in_ready = (st == W_IDLE);
  assign ch0      = (st == W_PULSE) && cur_sym[0];
  assign ch1      = (st == W_PULSE) && cur_sym[1];

endmodule

// File: rtl/tape_rd_classifier.sv
module tape_rd_classifier
  import tape_codec_pkg::*;
#(
  parameter int WIN_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in0,
  input  logic in1,
  output logic sym_valid,
  output sym_t sym
);
  localparam int WW = $clog2(WIN_TICKS + 1);

  logic [1:0]    prev;
  logic [1:0]    rise;
  logic [1:0]    seen;
  logic          win_open;
  logic [WW-1:0] wcnt;

  assign rise = {in1, in0} & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= '0;
      seen      <= '0;
      win_open  <= 1'b0;
      wcnt      <= '0;
      sym_valid <= 1'b0;
      sym       <= SYM_NONE;
    end else begin
      prev      <= {in1, in0};
      sym_valid <= 1'b0;
      if (!win_open) begin
        if (|rise) begin
          win_open <= 1'b1;
          seen     <= rise;
          wcnt     <= '0;
        end
      end else begin
        seen <= seen | rise;
        if (wcnt == WW'(WIN_TICKS - 1)) begin
          sym_valid <= 1'b1;
          sym       <= sym_t'(seen | rise);
          win_open  <= 1'b0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tape_rd_framer.sv
module tape_rd_framer
  import tape_codec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  sym_t              sym,
  input  logic              ctrl_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              irq,
  output logic              bof
);
  localparam int OVER = FRAME_BITS + 1;
  localparam logic [DATA_W-1:0] BOF_CODE = 8'h3C;

  logic                  synced;
  logic [IDX_W-1:0]      bcnt;
  logic [FRAME_BITS-1:0] fr;
  logic                  frame_ok;
  logic                  take;
  logic                  blocked;
  logic [DATA_W-1:0]     nxt_data;

  assign nxt_data = frame_data(fr);
  assign frame_ok = sym_valid && (sym == SYM_MARK) && synced && (bcnt == IDX_W'(FRAME_BITS));
  assign take     = !ctrl_mode || fr[CTRL_POS];
  assign blocked  = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced    <= 1'b0;
      bcnt      <= '0;
      fr        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      irq       <= 1'b0;
      bof       <= 1'b0;
    end else begin
      irq <= 1'b0;
      bof <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (sym_valid) begin
        if (sym == SYM_MARK) begin
          synced <= 1'b1;
          bcnt   <= '0;
          if (frame_ok && take && !blocked) begin
            out_valid <= 1'b1;
            out_data  <= nxt_data;
            irq       <= ctrl_mode;
            bof       <= ctrl_mode && (nxt_data == BOF_CODE);
          end
        end else if (synced && bcnt != IDX_W'(OVER)) begin
          fr   <= {fr[FRAME_BITS-2:0], (sym == SYM_ONE)};
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tape_byte_codec.sv
module tape_byte_codec
  import tape_codec_pkg::*;
#(
  parameter int GAP_TICKS   = 6400,
  parameter int PULSE_TICKS = 4160,
  parameter int WIN_TICKS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       wr_ctrl,
  output logic       tape_out0,
  output logic       tape_out1,
  input  logic       tape_in0,
  input  logic       tape_in1,
  input  logic       rd_ctrl_mode,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_irq,
  output logic       rd_bof
);
  logic sym_valid;
  sym_t sym;

  tape_wr_serializer #(
    .GAP_TICKS  (GAP_TICKS),
    .PULSE_TICKS(PULSE_TICKS)
  ) i_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(wr_valid),
    .in_data (wr_data),
    .in_ctrl (wr_ctrl),
    .in_ready(wr_ready),
    .ch0     (tape_out0),
    .ch1     (tape_out1)
  );

  tape_rd_classifier #(
    .WIN_TICKS(WIN_TICKS)
  ) i_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .in0      (tape_in0),
    .in1      (tape_in1),
    .sym_valid(sym_valid),
    .sym      (sym)
  );

  tape_rd_framer i_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_valid(sym_valid),
    .sym      (sym),
    .ctrl_mode(rd_ctrl_mode),
    .out_valid(rd_valid),
    .out_ready(rd_ready),
    .out_data (rd_data),
    .irq      (rd_irq),
    .bof      (rd_bof)
  );

endmodule

// File: rtl/tape_codec_chk.sv
module tape_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       tape_out0,
  input logic       tape_out1,
  input logic       rd_ctrl_mode,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       rd_irq,
  input logic       rd_bof
);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!tape_out0 && !tape_out1));

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R9
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_irq |-> (rd_valid && $past(rd_ctrl_mode)));

  // R10
  bof_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bof |-> (rd_irq && rd_data == 8'h3C));

endmodule

bind tape_byte_codec tape_codec_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .tape_out0   (tape_out0),
  .tape_out1   (tape_out1),
  .rd_ctrl_mode(rd_ctrl_mode),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .rd_irq      (rd_irq),
  .rd_bof      (rd_bof)
);

// File: tb/test_tape_byte_codec.sv
`timescale 1ns/1ps
module test_tape_byte_codec;
  localparam int GAP = 6;
  localparam int PUL = 4;
  localparam int WIN = 3;
  localparam int SYMP = GAP + PUL;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, wr_ctrl, rd_ctrl_mode, rd_ready;
  logic [7:0] wr_data;
  logic       wr_ready, tape_out0, tape_out1, rd_valid, rd_irq, rd_bof;
  logic [7:0] rd_data;
  logic       loop, inj0, inj1;
  logic       tin0, tin1;

  always #2 clk = ~clk;

  assign tin0 = loop ? tape_out0 : inj0;
  assign tin1 = loop ? tape_out1 : inj1;

  tape_byte_codec #(.GAP_TICKS(GAP), .PULSE_TICKS(PUL), .WIN_TICKS(WIN)) i_tape_byte_codec (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_ctrl(wr_ctrl), .tape_out0(tape_out0), .tape_out1(tape_out1),
    .tape_in0(tin0), .tape_in1(tin1), .rd_ctrl_mode(rd_ctrl_mode), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_irq(rd_irq), .rd_bof(rd_bof));

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int bof_cnt = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] exp_sym[$];
  logic [1:0] sym_log[$];
  int         rise_log[$];
  int         width_log[$];
  logic [1:0] prev_out = 2'b00;
  int         last_rise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pops on each handshake, plus writer symbol recorder
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7/R8/R9 unexpected frame", rd_data, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data == e, t, rd_data, e);
        end
      end
      if (rd_irq) irq_cnt++;
      if (rd_bof) bof_cnt++;
      if (prev_out == 2'b00 && {tape_out1, tape_out0} != 2'b00) begin
        sym_log.push_back({tape_out1, tape_out0});
        rise_log.push_back(cyc);
        last_rise = cyc;
      end
      if (prev_out != 2'b00 && {tape_out1, tape_out0} == 2'b00)
        width_log.push_back(cyc - last_rise);
    end
    prev_out = {tape_out1, tape_out0};
  end

  function automatic void push_syms(input logic [7:0] d, input logic c, input bit lead);
    logic [8:0] f;
    f = {d[7:4], c, d[3:0]};
    if (lead) exp_sym.push_back(2'b11);
    for (int i = 8; i >= 0; i--) exp_sym.push_back(f[i] ? 2'b10 : 2'b01);
    exp_sym.push_back(2'b11);
  endfunction

  task automatic send(input logic [7:0] d, input logic c);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_ctrl = c;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!wr_ready) @(negedge clk);
    repeat (WIN + 4) @(negedge clk);
  endtask

  task automatic inj(input logic [1:0] k);
    @(negedge clk);
    inj0 = k[0]; inj1 = k[1];
    repeat (2) @(negedge clk);
    inj0 = 1'b0; inj1 = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic inj_skew(input bit ch1_first, input int skew);
    @(negedge clk);
    if (ch1_first) inj1 = 1'b1; else inj0 = 1'b1;
    repeat (skew) @(negedge clk);
    inj0 = 1'b1; inj1 = 1'b1;
    repeat (2) @(negedge clk);
    inj0 = 1'b0; inj1 = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic inj_bits(input logic [8:0] f, input int n);
    for (int i = 8; i > 8 - n; i--) inj(f[i] ? 2'b10 : 2'b01);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int irq0, bof0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_ctrl = 1'b0;
    rd_ctrl_mode = 1'b0; rd_ready = 1'b1; loop = 1'b1; inj0 = 1'b0; inj1 = 1'b0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(wr_ready == 1'b1, "R12 wr_ready", wr_ready, 1);
    chk({tape_out1, tape_out0} == 2'b00, "R12 tape_out", {tape_out1, tape_out0}, 0);
    chk({rd_valid, rd_irq, rd_bof} == 3'b000, "R12 rd outputs", {rd_valid, rd_irq, rd_bof}, 0);
    rst_n = 1'b1;

    // loopback, data mode: R1 R2 R3 R4 R8
    push_syms(8'hA5, 1'b0, 1); exp_q.push_back(8'hA5); tag_q.push_back("R8 A5");
    push_syms(8'h3C, 1'b1, 0); exp_q.push_back(8'h3C); tag_q.push_back("R8 3C ctrl dropped");
    push_syms(8'h00, 1'b0, 0); exp_q.push_back(8'h00); tag_q.push_back("R8 00");
    push_syms(8'hFF, 1'b1, 0); exp_q.push_back(8'hFF); tag_q.push_back("R8 FF");
    send(8'hA5, 1'b0); send(8'h3C, 1'b1); send(8'h00, 1'b0); send(8'hFF, 1'b1);
    wait_idle();
    chk(sym_log.size() == 41, "R4 symbol count", sym_log.size(), 41);
    for (int i = 0; i < exp_sym.size() && i < sym_log.size(); i++)
      chk(sym_log[i] == exp_sym[i], "R1/R2 symbol", sym_log[i], exp_sym[i]);
    for (int i = 1; i < 11 && i < rise_log.size(); i++)
      chk(rise_log[i] - rise_log[i-1] == SYMP, "R3 symbol spacing", rise_log[i] - rise_log[i-1], SYMP);
    for (int i = 0; i < width_log.size(); i++)
      chk(width_log[i] == PUL, "R3 pulse width", width_log[i], PUL);
    chk(wr_ready == 1'b1, "R5 ready after closing mark", wr_ready, 1);
    chk(irq_cnt == 0, "R8 no irq in data mode", irq_cnt, 0);
    chk(exp_q.size() == 0, "R8 all frames delivered", exp_q.size(), 0);

    // loopback, control mode: R9 R10
    rd_ctrl_mode = 1'b1;
    irq0 = irq_cnt; bof0 = bof_cnt;
    exp_q.push_back(8'h3C); tag_q.push_back("R9/R10 3C");
    exp_q.push_back(8'h55); tag_q.push_back("R9 55");
    send(8'h12, 1'b0); send(8'h3C, 1'b1); send(8'h55, 1'b1);
    wait_idle();
    chk(irq_cnt - irq0 == 2, "R9 irq count", irq_cnt - irq0, 2);
    chk(bof_cnt - bof0 == 1, "R10 bof count", bof_cnt - bof0, 1);
    chk(exp_q.size() == 0, "R9 control frames delivered", exp_q.size(), 0);
    rd_ctrl_mode = 1'b0;

    // injection after reset: R6 R7
    @(negedge clk); rst_n = 1'b0; loop = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    irq0 = irq_cnt;
    inj_bits(9'h1AB, 9); inj(2'b11);              // unsynced: ignored
    inj_bits(9'h0F0, 8); inj_skew(0, 2);          // 8 bits: dropped
    inj_bits(9'h155, 9); inj(2'b01); inj_skew(1, 2); // 10 bits: dropped
    chk(rd_valid == 1'b0, "R7 short/long/unsynced discarded", rd_valid, 0);
    exp_q.push_back(8'h96); tag_q.push_back("R7 exact nine bits");
    inj_bits({4'h9, 1'b1, 4'h6}, 9); inj_skew(0, 3);  // mark with skew = window
    exp_q.push_back(8'hC1); tag_q.push_back("R6 split pair");
    inj_bits({4'hC, 1'b0, 4'h1}, 7);
    @(negedge clk); inj0 = 1'b1; repeat (6) @(negedge clk); inj1 = 1'b1;
    repeat (2) @(negedge clk); inj0 = 1'b0; inj1 = 1'b0; repeat (6) @(negedge clk);
    inj(2'b11);
    repeat (WIN + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R6/R7 injected frames", exp_q.size(), 0);
    chk(irq_cnt == irq0, "R8 no irq after injection", irq_cnt - irq0, 0);

    // back-pressure: R11
    loop = 1'b1; rd_ready = 1'b0;
    send(8'h5A, 1'b0); send(8'hA6, 1'b1);
    wait_idle();
    chk(rd_valid == 1'b1, "R11 held valid", rd_valid, 1);
    chk(rd_data == 8'h5A, "R11 held data", rd_data, 8'h5A);
    exp_q.push_back(8'h5A); tag_q.push_back("R11 first frame kept");
    rd_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_valid == 1'b0, "R11 second frame dropped", rd_valid, 0);
    chk(exp_q.size() == 0, "R11 queue empty", exp_q.size(), 0);

    finished = 1;
    finish_run();
  end

endmodule